// File: doc/BRIEF.md
# Hill-Climbing Autofocus Stepper Controller

This block finds the sharpest lens position by hill climbing. It drives a two-winding focus stepper motor with half-step excitation. A focus-measure stage outside the block scores each frame and reports one "sharper than last frame" bit with a valid strobe. The controller moves the motor one half step, waits for the next scored frame, and decides its next move from that bit.

When autofocus is enabled, the controller first runs a fixed direction probe. The probe has four legs of eight steps each, and the legs together return the lens to where it started. The controller counts the sharper flags seen in each leg and picks a climb direction from those counts. It then climbs one step per frame. Two non-improving frames in a row mark the peak. The motor then retreats two steps and the block raises `done`. A climb that reaches its step budget without finding a peak stops where it is and also raises `done`.

Top module: `focus_climber`

## Requirements
- R1: On a rising autofocus request from idle, the probe runs four legs of LEG_STEPS (default 8) steps each. The legs go forward, reverse, reverse, forward, so after the last probe step the bridge pattern equals the pattern at the start.
- R2: The per-leg flag counts are c1..c4. The climb direction is forward if c1 >= THRESH (default 6). Otherwise it is reverse if c2 >= THRESH.
- R3: If neither c1 nor c2 reaches THRESH, the climb is forward when c1+c4 >= c2+c3, including the tie, and reverse otherwise.
- R4: Every step, in the probe and in the climb, is followed by a wait for one valid flag. No further step is issued until that flag arrives, and a strobe that arrives while a step is being issued is not consumed.
- R5: During the climb, the second consecutive flag of 0 starts a back-off of exactly 2 steps opposite to the climb direction. After the back-off, `done` rises.
- R6: If STEP_LIMIT (default 1023) climb steps complete without a peak, the block raises `done` with no back-off. When the peak is confirmed on the flag of the last allowed step, the back-off is taken.
- R7: The motor phase index k runs 0..7. Its patterns {a_pos,a_neg,b_pos,b_neg} are 1000, 1010, 0010, 0110, 0100, 0101, 0001, 1001. A forward step is k+1 mod 8 and a reverse step is k-1 mod 8. A winding never has both ends high.
- R8: `done` stays high and the motor holds still while `af_en` stays high. Lowering `af_en` returns the block to idle, and `done` is low on the next cycle. While idle, valid strobes move nothing.
- R9: After reset, the phase index is 0 (pattern 1000) and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| af_en | input | 1 | Autofocus request; rising from idle starts a search |
| sharp_vld | input | 1 | Strobe: a new frame score is present |
| sharp_flag | input | 1 | 1 when the new frame is sharper than the previous one |
| a_pos | output | 1 | Winding A, positive-end bridge control |
| a_neg | output | 1 | Winding A, negative-end bridge control |
| b_pos | output | 1 | Winding B, positive-end bridge control |
| b_neg | output | 1 | Winding B, negative-end bridge control |
| done | output | 1 | Search finished; lens parked |

## Verification
Two exits from the climb can be due on the same frame: the confirmed peak and the exhausted step budget. The bench provokes this coincidence by holding the flag at 1 for 1021 climb steps and then sending two zeros. The second zero therefore lands on step 1023. The run is judged by the final bridge pattern, which must sit two steps short of the furthest position. A companion run with no zeros must stop exactly on step 1023, which confirms that the budget path alone leaves out the retreat.

// File: rtl/focus_pkg.sv
package focus_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MOVE,
        S_WAIT,
        S_DECIDE,
        S_BACK,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic a_pos;
        logic a_neg;
        logic b_pos;
        logic b_neg;
    } bridge_t;

    localparam int PHASES = 8;
    localparam int LEGS   = 4;

    // Half-step excitation: even index = one winding, odd = both windings.
    function automatic bridge_t half_step_pattern(input logic [2:0] idx);
        bridge_t p;
        case (idx)
            3'd0:    p = '{a_pos: 1'b1, a_neg: 1'b0, b_pos: 1'b0, b_neg: 1'b0};
            3'd1:    p = '{a_pos: 1'b1, a_neg: 1'b0, b_pos: 1'b1, b_neg: 1'b0};
            3'd2:    p = '{a_pos: 1'b0, a_neg: 1'b0, b_pos: 1'b1, b_neg: 1'b0};
            3'd3:    p = '{a_pos: 1'b0, a_neg: 1'b1, b_pos: 1'b1, b_neg: 1'b0};
            3'd4:    p = '{a_pos: 1'b0, a_neg: 1'b1, b_pos: 1'b0, b_neg: 1'b0};
            3'd5:    p = '{a_pos: 1'b0, a_neg: 1'b1, b_pos: 1'b0, b_neg: 1'b1};
            3'd6:    p = '{a_pos: 1'b0, a_neg: 1'b0, b_pos: 1'b0, b_neg: 1'b1};
            default: p = '{a_pos: 1'b1, a_neg: 1'b0, b_pos: 1'b0, b_neg: 1'b1};
        endcase
        return p;
    endfunction

    // Probe leg direction: legs 0 and 3 forward, legs 1 and 2 reverse.
    function automatic logic leg_is_forward(input logic [1:0] leg);
        return (leg == 2'd0) || (leg == 2'd3);
    endfunction

endpackage

// File: rtl/focus_phase_gen.sv
module focus_phase_gen
    import focus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  logic    step_fwd,
    output bridge_t drive
);
    logic [2:0] phase_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_idx <= 3'd0;
        end else if (step) begin
            phase_idx <= step_fwd ? phase_idx + 3'd1 : phase_idx - 3'd1;
        end
    end

    assign drive = half_step_pattern(phase_idx);
endmodule

// File: rtl/focus_probe_eval.sv
module focus_probe_eval
    import focus_pkg::*;
#(
    parameter int LEG_STEPS = 8,
    parameter int THRESH    = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       sample,
    input  logic       flag,
    input  logic [1:0] leg,
    output logic       dir_fwd
);
    localparam int CW = $clog2(LEG_STEPS + 1);
    localparam int SW = CW + 1;

    logic [CW-1:0] leg_sum [LEGS];

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                leg_sum[g] <= '0;
            end else if (sample && flag && (leg == 2'(g))) begin
                leg_sum[g] <= leg_sum[g] + 1'b1;
            end
        end
    end

    logic [SW-1:0] pair_fwd, pair_rev;

    always_comb begin
        pair_fwd = SW'(leg_sum[0]) + SW'(leg_sum[3]);
        pair_rev = SW'(leg_sum[1]) + SW'(leg_sum[2]);
        if (leg_sum[0] >= CW'(THRESH)) begin
            dir_fwd = 1'b1;
        end else if (leg_sum[1] >= CW'(THRESH)) begin
            dir_fwd = 1'b0;
        end else begin
            dir_fwd = (pair_fwd >= pair_rev);
        end
    end
endmodule

// File: rtl/focus_seq.sv
module focus_seq
    import focus_pkg::*;
#(
    parameter int LEG_STEPS  = 8,
    parameter int STEP_LIMIT = 1023
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       af_en,
    input  logic       sharp_vld,
    input  logic       sharp_flag,
    input  logic       decided_fwd,
    output logic       step,
    output logic       step_fwd,
    output logic       probe_sample,
    output logic       probe_clear,
    output logic [1:0] leg,
    output logic       done
);
    localparam int LW  = $clog2(LEG_STEPS + 1);
    localparam int CLW = $clog2(STEP_LIMIT + 1);

    seq_state_t     state;
    logic           probing;
    logic           climb_fwd;
    logic           zero_seen;
    logic           back_second;
    logic [LW-1:0]  leg_cnt;
    logic [CLW-1:0] climb_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            probing     <= 1'b0;
            climb_fwd   <= 1'b1;
            zero_seen   <= 1'b0;
            back_second <= 1'b0;
            leg         <= 2'd0;
            leg_cnt     <= '0;
            climb_cnt   <= '0;
        end else if (!af_en) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE: begin
                    state     <= S_MOVE;
                    probing   <= 1'b1;
                    leg       <= 2'd0;
                    leg_cnt   <= '0;
                    climb_cnt <= '0;
                    zero_seen <= 1'b0;
                end
                S_MOVE: begin
                    if (probing) leg_cnt <= leg_cnt + 1'b1;
                    else         climb_cnt <= climb_cnt + 1'b1;
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    if (sharp_vld) begin
                        if (probing) begin
                            if (leg_cnt == LW'(LEG_STEPS)) begin
                                leg_cnt <= '0;
                                if (leg == 2'd3) begin
                                    state <= S_DECIDE;
                                end else begin
                                    leg   <= leg + 2'd1;
                                    state <= S_MOVE;
                                end
                            end else begin
                                state <= S_MOVE;
                            end
                        end else if (!sharp_flag && zero_seen) begin
                            back_second <= 1'b0;
                            state       <= S_BACK;
                        end else begin
                            zero_seen <= !sharp_flag;
                            state     <= (climb_cnt == CLW'(STEP_LIMIT)) ? S_DONE : S_MOVE;
                        end
                    end
                end
                S_DECIDE: begin
                    climb_fwd <= decided_fwd;
                    probing   <= 1'b0;
                    state     <= S_MOVE;
                end
                S_BACK: begin
                    back_second <= 1'b1;
                    if (back_second) state <= S_DONE;
                end
                default: state <= S_DONE;
            endcase
        end
    end

    always_comb begin
        step         = af_en && ((state == S_MOVE) || (state == S_BACK));
        step_fwd     = (state == S_BACK) ? !climb_fwd
                     : (probing ? leg_is_forward(leg) : climb_fwd);
        probe_sample = af_en && (state == S_WAIT) && sharp_vld && probing;
        probe_clear  = (state == S_IDLE);
        done         = (state == S_DONE);
    end
endmodule

// File: rtl/focus_climber.sv
module focus_climber
    import focus_pkg::*;
#(
    parameter int LEG_STEPS  = 8,
    parameter int THRESH     = 6,
    parameter int STEP_LIMIT = 1023
) (
    input  logic clk,
    input  logic rst,
    input  logic af_en,
    input  logic sharp_vld,
    input  logic sharp_flag,
    output logic a_pos,
    output logic a_neg,
    output logic b_pos,
    output logic b_neg,
    output logic done
);
    logic       step, step_fwd, probe_sample, probe_clear, decided_fwd;
    logic [1:0] leg;
    bridge_t    drive;

    focus_seq #(.LEG_STEPS(LEG_STEPS), .STEP_LIMIT(STEP_LIMIT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .af_en        (af_en),
        .sharp_vld    (sharp_vld),
        .sharp_flag   (sharp_flag),
        .decided_fwd  (decided_fwd),
        .step         (step),
        .step_fwd     (step_fwd),
        .probe_sample (probe_sample),
        .probe_clear  (probe_clear),
        .leg          (leg),
        .done         (done)
    );

    focus_probe_eval #(.LEG_STEPS(LEG_STEPS), .THRESH(THRESH)) u_eval (
        .clk     (clk),
        .rst     (rst),
        .clear   (probe_clear),
        .sample  (probe_sample),
        .flag    (sharp_flag),
        .leg     (leg),
        .dir_fwd (decided_fwd)
    );

    focus_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .step_fwd (step_fwd),
        .drive    (drive)
    );

    assign a_pos = drive.a_pos;
    assign a_neg = drive.a_neg;
    assign b_pos = drive.b_pos;
    assign b_neg = drive.b_neg;
endmodule

// File: rtl/focus_climber_chk.sv
module focus_climber_chk (
    input logic clk,
    input logic rst,
    input logic af_en,
    input logic a_pos,
    input logic a_neg,
    input logic b_pos,
    input logic b_neg,
    input logic done
);
    // R7: a winding is never driven from both ends
    assert_wind_a_R7: assert property (@(posedge clk) disable iff (rst) !(a_pos && a_neg));
    assert_wind_b_R7: assert property (@(posedge clk) disable iff (rst) !(b_pos && b_neg));
    // R7: half-step patterns energise one or two ends
    assert_energised_R7: assert property (@(posedge clk) disable iff (rst)
        ($countones({a_pos, a_neg, b_pos, b_neg}) >= 1) && ($countones({a_pos, a_neg, b_pos, b_neg}) <= 2));
    // R8: dropping the request clears done
    assert_drop_clears_R8: assert property (@(posedge clk) disable iff (rst) !af_en |=> !done);
    // R5: once parked, the motor holds
    assert_parked_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable({a_pos, a_neg, b_pos, b_neg}));
    // R9: reset state
    assert_reset_R9: assert property (@(posedge clk)
        $past(rst) |-> ({a_pos, a_neg, b_pos, b_neg} == 4'b1000) && !done);
endmodule

bind focus_climber focus_climber_chk i_chk (
    .clk   (clk),
    .rst   (rst),
    .af_en (af_en),
    .a_pos (a_pos),
    .a_neg (a_neg),
    .b_pos (b_pos),
    .b_neg (b_neg),
    .done  (done)
);

// File: tb/test_focus_climber.sv
module test_focus_climber;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic af_en = 1'b0;
    logic sharp_vld = 1'b0;
    logic sharp_flag = 1'b0;
    logic a_pos, a_neg, b_pos, b_neg, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pos = 0;

    always #2 clk = ~clk;

    focus_climber i_focus_climber (
        .clk(clk), .rst(rst), .af_en(af_en), .sharp_vld(sharp_vld), .sharp_flag(sharp_flag),
        .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg), .done(done)
    );

    // Stimulus table: probe flags (leg1 in [7:0] .. leg4 in [31:24]),
    // first 16 climb flags, index from which later climb flags are 0, expected net move.
    localparam int NV = 7;
    localparam logic [31:0] V_PROBE [NV] = '{32'h000000FF, 32'h00003F1F, 32'h073F031F,
                                             32'h0007030F, 32'h0000FF3F, 32'hFFFFFFFF, 32'hFFFFFFFF};
    localparam logic [15:0] V_CLIMB [NV] = '{16'h0007, 16'h0005, 16'h0000, 16'h003F,
                                             16'h0001, 16'hFFFF, 16'hFFFF};
    localparam int V_ZPOS [NV] = '{2047, 2047, 2047, 2047, 2047, 2047, 1021};
    localparam int V_NET  [NV] = '{3, -3, 0, -6, 1, 1023, 1021};
    localparam string V_REQ [NV] = '{"R2", "R2", "R3", "R3", "R2", "R6", "R6"};

    function automatic logic [3:0] pat(input int p);
        case (p & 7)
            0: return 4'b1000;  1: return 4'b1010;
            2: return 4'b0010;  3: return 4'b0110;
            4: return 4'b0100;  5: return 4'b0101;
            6: return 4'b0001;  default: return 4'b1001;
        endcase
    endfunction

    function automatic logic [3:0] outs();
        return {a_pos, a_neg, b_pos, b_neg};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic f);
        @(negedge clk);
        sharp_vld  = 1'b1;
        sharp_flag = f;
        @(negedge clk);
        sharp_vld  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic excl_bad = 1'b0;
    always @(negedge clk) if (!rst && ((a_pos && a_neg) || (b_pos && b_neg))) excl_bad = 1'b1;

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", {28'd0, outs()}, {28'd0, 4'b1000});
        check("R9", {31'd0, done}, 32'd0);
        rst = 1'b0;

        // R8: strobes while idle move nothing
        for (int k = 0; k < 3; k++) pulse(1'b1);
        check("R8", {28'd0, outs()}, {28'd0, pat(pos)});

        for (int v = 0; v < NV; v++) begin
            int start;
            int j;
            start = pos;
            @(negedge clk);
            af_en = 1'b1;
            @(negedge clk);
            @(negedge clk);
            if (v == 0) begin
                // R4: first probe step forward, then the motor waits for a flag
                check("R4", {28'd0, outs()}, {28'd0, pat(start + 1)});
                repeat (4) @(negedge clk);
                check("R4", {28'd0, outs()}, {28'd0, pat(start + 1)});
            end
            j = 0;
            while (!done && j < 1200) begin
                logic f;
                if (j < 32) f = V_PROBE[v][j];
                else if (j - 32 < 16) f = V_CLIMB[v][j - 32];
                else f = (j - 32 >= V_ZPOS[v]) ? 1'b0 : 1'b1;
                @(negedge clk);
                sharp_vld  = 1'b1;
                sharp_flag = f;
                @(negedge clk);
                sharp_vld  = 1'b0;
                // R1: after the last probe flag the lens is back at the start
                if (j == 31) check("R1", {28'd0, outs()}, {28'd0, pat(start)});
                repeat (2) @(negedge clk);
                j++;
            end
            repeat (4) @(negedge clk);
            pos = start + V_NET[v];
            check(V_REQ[v], {31'd0, done}, 32'd1);
            check(v >= 5 ? "R6" : "R5", {28'd0, outs()}, {28'd0, pat(pos)});
            af_en = 1'b0;
            @(negedge clk);
            @(negedge clk);
            // R8: done clears once the request drops
            check("R8", {31'd0, done}, 32'd0);
        end

        // R7: no winding ever driven from both ends
        check("R7", {31'd0, excl_bad}, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule